// File: doc/BRIEF.md
# Read-Only SPI FIFO Drain Port

This block is a read-only SPI slave through which an external master empties a FIFO of sensor-channel samples. Each frame, bounded by the select line being low, starts with one status byte, followed by as many data bytes as the master clocks out. Data bytes are taken from the head of the FIFO. The FIFO itself lives outside the block; the block only sees its empty flag, its head word and an overflow pulse, and it returns a pop strobe.

The status byte has a four-bit check field in its top nibble. This field steps by one at the end of every frame, so a master reading the same value twice in a row knows the link is stuck. The low nibble reports whether the FIFO is empty, whether an overflow happened since the last report, and whether data is available.

The SPI clock and select pass through two-flop synchronizers into the system clock domain, and all logic runs on edges detected there. The system clock must be at least eight times faster than the SPI clock. The SPI mode is clock idle low, with data changed after the rising edge and sampled by the master on the falling edge.

Top module: `spi_fifo_pipe`

## Requirements
- R1: After reset, `spi_miso_o` and `fifo_pop_o` are 0, and the check field of the first status byte is binary 0101.
- R2: While select is low, the MISO bit changes only after a rising SPI clock edge and holds through the following falling edge. Each byte takes eight rising edges and is sent MSB first.
- R3: Bit 7 of the status byte appears on MISO within three system clocks of select falling, before any SPI clock edge. It stays there through the first rising edge.
- R4: A frame carries the status byte first and then data bytes, back to back, for as long as the master keeps clocking.
- R5: The status byte is captured when select falls. Bits 7:4 hold the check field, bit 3 is 1 when the FIFO is empty, bit 2 is the overflow flag, bit 1 is 1 when the FIFO is not empty, and bit 0 is 0.
- R6: The check field increases by one (modulo 16) each time select rises.
- R7: A one-cycle pulse on `fifo_ovf_i` sets the overflow flag. The flag is reported in the next status byte and then cleared, unless a new pulse arrives in the capture cycle.
- R8: At the first rising edge of each data byte, if the FIFO is not empty, the block raises `fifo_pop_o` for exactly one cycle and shifts out the head word captured in that cycle.
- R9: A data byte that starts while the FIFO is empty is sent as all zeros, and no pop is issued.
- R10: Within three system clocks of select rising, MISO returns to 0 and stays 0 while select is high. A partly sent byte is dropped, and the next frame starts again with a status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SPI clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck_i | input | 1 | SPI clock from the master, idle low |
| spi_csn_i | input | 1 | Active-low frame select from the master |
| spi_miso_o | output | 1 | Serial data to the master |
| fifo_empty_i | input | 1 | FIFO holds no entry |
| fifo_ovf_i | input | 1 | One-cycle pulse when the FIFO dropped a write |
| fifo_rdata_i | input | 8 | Head word of the FIFO (first-word fall-through) |
| fifo_pop_o | output | 1 | Removes the head word of the FIFO |

## Verification
On every cycle, the assertions check these rules: a pop never happens on an empty FIFO, is one cycle wide and occurs only inside a frame; MISO is low once select has been high for a few cycles; the check field steps by one at every frame end; the overflow flag sets on a pulse and clears on capture; and the first status bit appears right after the frame starts. Only the bench scenarios can show the byte contents. These are the full status encoding, the order of data bytes across frames, zero fill once the FIFO runs dry, and the resumption after an aborted byte, in which the popped word is lost and the next frame opens with status. The bench checks these against its own FIFO and status model.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

  localparam int unsigned PIPE_DATA_W = 8;
  localparam int unsigned PIPE_CHK_W  = 4;
  localparam logic [PIPE_CHK_W-1:0] PIPE_CHK_INIT = 4'b0101;
  localparam int unsigned PIPE_SYNC_STAGES = 2;

  // low status flags, MSB first as they appear on the wire
  typedef struct packed {
    logic empty;
    logic ovf;
    logic valid;
  } pipe_flags_t;

  localparam int unsigned PIPE_FLAGS_W = $bits(pipe_flags_t);

endpackage

// File: rtl/pipe_rst_sync.sv
module pipe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/pipe_sync_edge.sv
module pipe_sync_edge #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  // stages 0..STAGES-1 synchronize, the last bit is the delayed copy
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {(STAGES+1){RESET_VAL}};
    else         chain_q <= chain_d;
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o  = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/pipe_status.sv
module pipe_status
  import pipe_pkg::*;
#(
  parameter int unsigned DATA_W = PIPE_DATA_W,
  parameter int unsigned CHK_W  = PIPE_CHK_W,
  parameter logic [CHK_W-1:0] CHK_INIT = PIPE_CHK_INIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_ovf_i,
  output logic [DATA_W-1:0] status_o,
  output logic [CHK_W-1:0]  chk_o,
  output logic              ovf_o
);

  localparam int unsigned PAD_W = DATA_W - CHK_W - PIPE_FLAGS_W;

  logic [CHK_W-1:0] chk_q, chk_d;
  logic             ovf_q, ovf_d;
  logic             chk_en;
  pipe_flags_t      flags;

  assign chk_en = frame_end_i;

  always_comb begin
    chk_d = chk_q;
    if (chk_en) chk_d = chk_q + 1'b1;
  end

  // a fresh pulse wins over the clear caused by reporting
  always_comb begin
    ovf_d = fifo_ovf_i | (ovf_q & ~frame_start_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= CHK_INIT;
      ovf_q <= 1'b0;
    end else begin
      chk_q <= chk_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    flags.empty = fifo_empty_i;
    flags.ovf   = ovf_q;
    flags.valid = ~fifo_empty_i;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_o = {chk_q, flags, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign status_o = {chk_q, flags};
    end
  endgenerate

  assign chk_o = chk_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/pipe_shifter.sv
module pipe_shifter
  import pipe_pkg::*;
#(
  parameter int unsigned DATA_W = PIPE_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              sck_rise_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  output logic              fifo_pop_o,
  output logic              miso_o,
  output logic              active_o
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic              lead_q, lead_d;
  logic              active_q, active_d;
  logic              pop;
  logic              step_en;

  assign step_en = active_q & sck_rise_i;

  always_comb begin
    shreg_d  = shreg_q;
    bitcnt_d = bitcnt_q;
    lead_d   = lead_q;
    active_d = active_q;
    pop      = 1'b0;
    if (frame_end_i) begin
      active_d = 1'b0;
      lead_d   = 1'b0;
      shreg_d  = '0;
      bitcnt_d = '0;
    end else if (frame_start_i) begin
      active_d = 1'b1;
      lead_d   = 1'b1;
      shreg_d  = status_i;
      bitcnt_d = '0;
    end else if (step_en) begin
      if (lead_q) begin
        // first rising edge: MSB already presented, master samples it on fall
        lead_d = 1'b0;
      end else if (bitcnt_q == LAST_BIT) begin
        bitcnt_d = '0;
        if (!fifo_empty_i) begin
          shreg_d = fifo_rdata_i;
          pop     = 1'b1;
        end else begin
          shreg_d = '0;
        end
      end else begin
        shreg_d  = {shreg_q[DATA_W-2:0], 1'b0};
        bitcnt_d = bitcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      bitcnt_q <= '0;
      lead_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      shreg_q  <= shreg_d;
      bitcnt_q <= bitcnt_d;
      lead_q   <= lead_d;
      active_q <= active_d;
    end
  end

  assign fifo_pop_o = pop;
  assign miso_o     = active_q & shreg_q[DATA_W-1];
  assign active_o   = active_q;

endmodule

// File: rtl/spi_fifo_pipe.sv
module spi_fifo_pipe
  import pipe_pkg::*;
#(
  parameter int unsigned DATA_W      = PIPE_DATA_W,
  parameter int unsigned CHK_W       = PIPE_CHK_W,
  parameter logic [CHK_W-1:0] CHK_INIT = PIPE_CHK_INIT,
  parameter int unsigned SYNC_STAGES = PIPE_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sck_i,
  input  logic              spi_csn_i,
  output logic              spi_miso_o,
  input  logic              fifo_empty_i,
  input  logic              fifo_ovf_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  output logic              fifo_pop_o
);

  logic              rst_n_sync;
  logic              sck_level, sck_rise, sck_fall;
  logic              csn_level, csn_rise, csn_fall;
  logic              frame_start_w, frame_end_w;
  logic [DATA_W-1:0] status_w;
  logic [CHK_W-1:0]  chk_w;
  logic              ovf_w;
  logic              active_w;

  pipe_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_sync)
  );

  pipe_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sck (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .async_i (spi_sck_i),
    .level_o (sck_level),
    .rise_o  (sck_rise),
    .fall_o  (sck_fall)
  );

  pipe_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_csn (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .async_i (spi_csn_i),
    .level_o (csn_level),
    .rise_o  (csn_rise),
    .fall_o  (csn_fall)
  );

  // rising SCK counts only while select is seen low
  logic sck_rise_q;
  assign sck_rise_q    = sck_rise & ~csn_level & ~sck_fall;
  assign frame_start_w = csn_fall;
  assign frame_end_w   = csn_rise;

  pipe_status #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CHK_INIT(CHK_INIT)) u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_sync),
    .frame_start_i (frame_start_w),
    .frame_end_i   (frame_end_w),
    .fifo_empty_i  (fifo_empty_i),
    .fifo_ovf_i    (fifo_ovf_i),
    .status_o      (status_w),
    .chk_o         (chk_w),
    .ovf_o         (ovf_w)
  );

  pipe_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_sync),
    .frame_start_i (frame_start_w),
    .frame_end_i   (frame_end_w),
    .sck_rise_i    (sck_rise_q),
    .status_i      (status_w),
    .fifo_empty_i  (fifo_empty_i),
    .fifo_rdata_i  (fifo_rdata_i),
    .fifo_pop_o    (fifo_pop_o),
    .miso_o        (spi_miso_o),
    .active_o      (active_w)
  );

  logic unused_level;
  assign unused_level = sck_level;

endmodule

// File: rtl/pipe_checker.sv
module pipe_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CHK_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              miso_i,
  input logic              pop_i,
  input logic              empty_i,
  input logic              ovf_pulse_i,
  input logic              active_i,
  input logic              frame_start_i,
  input logic              frame_end_i,
  input logic [CHK_W-1:0]  chk_i,
  input logic              ovf_flag_i,
  input logic [DATA_W-1:0] status_i
);

  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_i);

  assert_single_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> !pop_i);

  assert_pop_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> active_i);

  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !miso_i);

  assert_check_steps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (chk_i == CHK_W'($past(chk_i) + 1'b1)));

  assert_ovf_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_i |=> ovf_flag_i);

  assert_ovf_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !ovf_pulse_i) |=> !ovf_flag_i);

  assert_first_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (miso_i == $past(status_i[DATA_W-1])));

endmodule

bind spi_fifo_pipe pipe_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_pipe_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csn_i         (spi_csn_i),
  .miso_i        (spi_miso_o),
  .pop_i         (fifo_pop_o),
  .empty_i       (fifo_empty_i),
  .ovf_pulse_i   (fifo_ovf_i),
  .active_i      (active_w),
  .frame_start_i (frame_start_w),
  .frame_end_i   (frame_end_w),
  .chk_i         (chk_w),
  .ovf_flag_i    (ovf_w),
  .status_i      (status_w)
);

// File: tb/spi_fifo_pipe_test.sv
`timescale 1ns/1ps
module spi_fifo_pipe_test;

  localparam int HALF = 5;

  logic       clk;
  logic       rst_n;
  logic       sck;
  logic       csn;
  logic       miso;
  logic       fifo_empty;
  logic       fifo_ovf;
  logic [7:0] fifo_rdata;
  logic       fifo_pop;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench-side FIFO
  logic [7:0] mem [256];
  int wr = 0;
  int rd = 0;
  bit underflow = 0;

  // expected model
  logic [3:0] exp_chk = 4'b0101;
  bit         exp_ovf = 0;
  int         exp_rd  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign fifo_empty = (rd == wr);
  assign fifo_rdata = mem[rd % 256];

  always @(posedge clk) begin
    if (fifo_pop) begin
      if (rd == wr) underflow <= 1;
      else          rd <= rd + 1;
    end
  end

  spi_fifo_pipe uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .spi_sck_i    (sck),
    .spi_csn_i    (csn),
    .spi_miso_o   (miso),
    .fifo_empty_i (fifo_empty),
    .fifo_ovf_i   (fifo_ovf),
    .fifo_rdata_i (fifo_rdata),
    .fifo_pop_o   (fifo_pop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_of(input logic [3:0] chk, input bit ovf, input int cnt);
    return {chk, (cnt == 0), ovf, (cnt != 0), 1'b0};
  endfunction

  task automatic push(input logic [7:0] v);
    mem[wr % 256] = v;
    wr++;
  endtask

  task automatic pulse_ovf();
    @(negedge clk) fifo_ovf = 1'b1;
    @(negedge clk) fifo_ovf = 1'b0;
    exp_ovf = 1;
  endtask

  task automatic frame(input int nwords, input int extra);
    int total;
    logic [7:0] acc;
    logic [7:0] exp_word;
    logic [7:0] st;
    bit stable_ok;
    total = nwords * 8 + extra;
    st = status_of(exp_chk, exp_ovf, wr - exp_rd);
    exp_ovf = 0;
    exp_word = st;
    acc = '0;
    stable_ok = 1;
    @(negedge clk) csn = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 first status bit before clock", miso, st[7]);
    for (int i = 0; i < total; i++) begin
      logic b;
      logic b_late;
      if (i % 8 == 0 && i >= 8) begin
        if (wr - exp_rd > 0) begin
          exp_word = mem[exp_rd % 256];
          exp_rd++;
        end else begin
          exp_word = 8'h00;
        end
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      b = miso;
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
      b_late = miso;
      if (b !== b_late) stable_ok = 0;
      acc = {acc[6:0], b};
      if (i % 8 == 7) begin
        if (i < 8) check("R5 status byte", acc, exp_word);
        else if (wr - exp_rd >= 0 && exp_word == 8'h00) check("R9 zero fill or data", acc, exp_word);
        else check("R4 R8 data byte", acc, exp_word);
      end
    end
    check("R2 bit held across falling edge", stable_ok, 1);
    csn = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle MISO after select high", miso, 1'b0);
    exp_chk = exp_chk + 4'd1;
    repeat (4) @(negedge clk);
    check("R8 pop count", rd, exp_rd);
    check("R9 no underflow", underflow, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; csn = 1'b1; sck = 1'b0; fifo_ovf = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 reset MISO", miso, 1'b0);
    check("R1 reset pop", fifo_pop, 1'b0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 idle MISO after reset", miso, 1'b0);

    // R1 R9: empty FIFO, check field starts at 0101 -> status 0x58
    check("R1 expected first status", status_of(exp_chk, 0, 0), 8'h58);
    frame(3, 0);

    // R7: overflow reported once, then cleared
    push(8'hA5); push(8'h3C); push(8'hF0);
    pulse_ovf();
    frame(2, 0);
    frame(2, 0);

    // R10: abort inside a data byte, next frame restarts with status
    push(8'h81); push(8'h7E); push(8'h55); push(8'hC3);
    frame(1, 3);
    frame(3, 0);

    // R9: more bytes requested than stored
    push(8'h99);
    frame(4, 0);

    // R6: frames without data walk the check field through a wrap
    for (int k = 0; k < 17; k++) frame(1, 0);

    // random mix
    for (int k = 0; k < 30; k++) begin
      int np;
      np = $urandom_range(0, 4);
      for (int j = 0; j < np; j++) push(8'($urandom));
      if ($urandom_range(0, 3) == 0) pulse_ovf();
      frame($urandom_range(1, 4), ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule